// File: doc/BRIEF.md
# Display Address Register File for a Character CRT Timer

This block keeps the three 12-bit addresses that a character-mode CRT timing controller needs: the address of the first character shown on the screen (page top), the address from which the current text row is fetched (row base), and the character position of the cursor. A host loads one of them at a time by presenting a 2-bit target code and a 12-bit address together with a valid strobe. The three values are always visible on registered outputs, where a display address generator reads them.

The result of a row-base write depends on where the beam is. The block compares the current scan line with the number of visible scan lines. While the beam is inside the visible area, a row-base write lands in the row-base register. Once the beam reaches the blanking interval, the same write is sent to the page-top register instead. This lets software set the start of the next frame with the same command it uses to scroll within a frame.

Load requests flow in on a valid-qualified interface with no back-pressure. The block accepts every beat on which `ld_valid` is high, at the next rising clock edge, so it has no ready output. The scan-line inputs are plain status pins.

Top module: `crtc_addr_regfile`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, all three outputs read 0.
- R2: A valid load with code 1 (`ld_sel` = 2'b01) copies `ld_addr` into `page_top`. The new value shows after the next rising edge.
- R3: A valid load with code 2 (`ld_sel` = 2'b10) made while `scan_line` < `vis_lines` copies `ld_addr` into `row_base`. `page_top` is left unchanged.
- R4: A valid load with code 2 made while `scan_line` >= `vis_lines` copies `ld_addr` into `page_top`. `row_base` keeps its value.
- R5: A valid load with code 3 (`ld_sel` = 2'b11) copies `ld_addr` into `cursor_pos`.
- R6: A valid load with code 0 (`ld_sel` = 2'b00) changes none of the three outputs.
- R7: While `ld_valid` is low, all outputs hold their values whatever the other inputs do.
- R8: `scan_line` and `vis_lines` are 9-bit unsigned values. A line equal to the limit counts as blanking, and so does every line when the limit is 0. The line one below the limit counts as visible.
- R9: Each load changes only the register it targets. The other two outputs keep their values in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset, synchronous |
| ld_valid | input | 1 | A load request is present this cycle and is always accepted |
| ld_sel | input | 2 | Target code: 0 none, 1 page top, 2 row base (page top in blanking), 3 cursor |
| ld_addr | input | 12 | Address value to load |
| scan_line | input | 9 | Current scan line, unsigned |
| vis_lines | input | 9 | Number of visible scan lines, unsigned |
| page_top | output | 12 | Page-top address register |
| row_base | output | 12 | Row-base address register |
| cursor_pos | output | 12 | Cursor address register |

## Verification
The assertions check on every cycle that:
- the load enables are never active for more than one register;
- each register takes the presented address exactly when it is enabled and otherwise holds its value;
- the page-top and row-base outputs follow the redirection rule for code-2 loads.

Only the bench scenarios show the reset values and the exact boundary of the unsigned comparison (line equal to the limit, one below it, and a limit of zero). They also show that long random mixes of codes and line positions leave every register matching an independent model.

// File: rtl/crtc_addr_pkg.sv
package crtc_addr_pkg;
  parameter int ADDR_W = 12;
  parameter int LINE_W = 9;
  parameter int NREGS  = 3;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_TOP  = 2'd1,
    SEL_ROW  = 2'd2,
    SEL_CUR  = 2'd3
  } sel_e;

  // Index of each register in the bank.
  localparam int IDX_TOP = 0;
  localparam int IDX_ROW = 1;
  localparam int IDX_CUR = 2;
endpackage

// File: rtl/crtc_blank_cmp.sv
module crtc_blank_cmp #(
  parameter int LINE_W = 9
) (
  input  logic [LINE_W-1:0] line_i,
  input  logic [LINE_W-1:0] limit_i,
  output logic              blank_o
);
  // Unsigned compare: at or past the visible count means blanking.
  always_comb begin
    blank_o = (line_i >= limit_i);
  end
endmodule

// File: rtl/crtc_target_decode.sv
module crtc_target_decode
  import crtc_addr_pkg::*;
#(
  parameter int NR = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid_i,
  input  logic [1:0]    sel_i,
  input  logic          blank_i,
  output logic [NR-1:0] en_o
);
  always_comb begin
    en_o = '0;
    if (valid_i) begin
      unique case (sel_e'(sel_i))
        SEL_TOP: en_o[IDX_TOP] = 1'b1;
        SEL_ROW: begin
          if (blank_i) en_o[IDX_TOP] = 1'b1;
          else         en_o[IDX_ROW] = 1'b1;
        end
        SEL_CUR: en_o[IDX_CUR] = 1'b1;
        default: en_o = '0;
      endcase
    end
  end

  // R9
  en_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(en_o));

  // R6
  sel_none_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == 2'd0) |-> (en_o == '0));
endmodule

// File: rtl/crtc_addr_reg.sv
module crtc_addr_reg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q_o <= '0;
    else if (en_i) q_o <= d_i;
  end

  // R2
  reg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |=> (q_o == $past(d_i)));

  // R7
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(q_o));
endmodule

// File: rtl/crtc_addr_regfile.sv
module crtc_addr_regfile
  import crtc_addr_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int LW = LINE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_valid,
  input  logic [1:0]    ld_sel,
  input  logic [AW-1:0] ld_addr,
  input  logic [LW-1:0] scan_line,
  input  logic [LW-1:0] vis_lines,
  output logic [AW-1:0] page_top,
  output logic [AW-1:0] row_base,
  output logic [AW-1:0] cursor_pos
);
  localparam int NR = NREGS;

  logic          in_blank;
  logic [NR-1:0] load_en;
  logic [AW-1:0] bank_q [NR];

  crtc_blank_cmp #(.LINE_W(LW)) blank_i (
    .line_i  (scan_line),
    .limit_i (vis_lines),
    .blank_o (in_blank)
  );

  crtc_target_decode #(.NR(NR)) dec_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (ld_valid),
    .sel_i   (ld_sel),
    .blank_i (in_blank),
    .en_o    (load_en)
  );

  for (genvar g = 0; g < NR; g++) begin : g_bank
    crtc_addr_reg #(.W(AW)) reg_i (
      .clk   (clk),
      .rst_n (rst_n),
      .en_i  (load_en[g]),
      .d_i   (ld_addr),
      .q_o   (bank_q[g])
    );
  end

  assign page_top   = bank_q[IDX_TOP];
  assign row_base   = bank_q[IDX_ROW];
  assign cursor_pos = bank_q[IDX_CUR];

  // R3
  row_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_sel == 2'd2 && scan_line < vis_lines)
      |=> (row_base == $past(ld_addr)) && $stable(page_top));

  // R4
  row_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_sel == 2'd2 && scan_line >= vis_lines)
      |=> (page_top == $past(ld_addr)) && $stable(row_base));

  // R5
  cursor_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_sel == 2'd3)
      |=> (cursor_pos == $past(ld_addr)) && $stable(page_top) && $stable(row_base));

  // R6
  sel_none_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_sel == 2'd0)
      |=> $stable(page_top) && $stable(row_base) && $stable(cursor_pos));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |=> $stable(page_top) && $stable(row_base) && $stable(cursor_pos));
endmodule

// File: tb/crtc_addr_regfile_tb.sv
module crtc_addr_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0;
  logic [1:0]  ld_sel = 2'd0;
  logic [11:0] ld_addr = 12'd0;
  logic [8:0]  scan_line = 9'd0;
  logic [8:0]  vis_lines = 9'd240;
  logic [11:0] page_top, row_base, cursor_pos;

  int total = 0;
  int bad = 0;
  int m_top = 0, m_row = 0, m_cur = 0;

  always #5 clk = ~clk;

  crtc_addr_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_sel(ld_sel),
    .ld_addr(ld_addr), .scan_line(scan_line), .vis_lines(vis_lines),
    .page_top(page_top), .row_base(row_base), .cursor_pos(cursor_pos)
  );

  task automatic cmp(input string tag);
    total++;
    if (page_top !== 12'(m_top) || row_base !== 12'(m_row) ||
        cursor_pos !== 12'(m_cur)) begin
      bad++;
      $display("FAIL %s: got top=%03h row=%03h cur=%03h exp top=%03h row=%03h cur=%03h",
               tag, page_top, row_base, cursor_pos, m_top, m_row, m_cur);
    end
  endtask

  // Drive at negedge, reference model updates at the edge, compare at next negedge.
  task automatic step(input bit v, input int sel, input int addr,
                      input int line, input int vis, input string tag);
    ld_valid  = v;
    ld_sel    = 2'(sel);
    ld_addr   = 12'(addr);
    scan_line = 9'(line);
    vis_lines = 9'(vis);
    @(posedge clk);
    if (v) begin
      if (sel == 1) m_top = addr & 12'hfff;
      else if (sel == 2) begin
        if ((line & 9'h1ff) >= (vis & 9'h1ff)) m_top = addr & 12'hfff;
        else m_row = addr & 12'hfff;
      end
      else if (sel == 3) m_cur = addr & 12'hfff;
    end
    @(negedge clk);
    cmp(tag);
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cmp("R1 in reset");
    ld_valid = 1'b1; ld_sel = 2'd3; ld_addr = 12'hfff;
    @(negedge clk);
    cmp("R1 load ignored in reset");
    ld_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R1 after release");

    step(1, 1, 'h123, 10, 240, "R2 page top load");
    step(1, 2, 'h456, 10, 240, "R3 row base visible");
    step(1, 3, 'h789, 10, 240, "R5 cursor load");
    step(1, 2, 'habc, 240, 240, "R4 redirect at limit R8");
    step(1, 2, 'h0de, 239, 240, "R3 one below limit R8");
    step(1, 2, 'h5a5, 300, 240, "R4 redirect past limit");
    step(1, 2, 'h111, 0, 0, "R8 zero limit redirects");
    step(1, 2, 'h222, 511, 0, "R8 unsigned max line");
    step(1, 2, 'h333, 0, 511, "R8 line 0 visible");
    step(1, 0, 'hfff, 10, 240, "R6 code zero");
    step(1, 0, 'h000, 300, 240, "R6 code zero in blank");
    step(0, 1, 'hbad, 10, 240, "R7 no valid code1");
    step(0, 2, 'hbad, 300, 240, "R7 no valid code2");
    step(0, 3, 'hbad, 10, 240, "R7 no valid code3");
    step(1, 3, 'h000, 10, 240, "R9 cursor only");
    step(1, 1, 'hfff, 300, 240, "R9 top only");
    step(1, 3, 'h001, 10, 240, "R5 back to back 1");
    step(1, 3, 'h002, 10, 240, "R5 back to back 2");

    for (int i = 0; i < 3000; i++) begin
      int v, s, a, l, vl;
      v  = ($urandom % 4) != 0;
      s  = $urandom % 4;
      a  = $urandom % 4096;
      l  = $urandom % 512;
      vl = ($urandom % 8 == 0) ? l : $urandom % 512;
      step(v[0], s, a, l, vl, "R9 random mix");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule